// File: doc/BRIEF.md
# Thread-Tagged Dependence Record Logger

This block sits beside one processor's private cache in a record-and-replay system that works by tagging cache lines. Scheduling software programs the identity of the thread that is about to run: a thread number, the sphere that the thread belongs to, and an operating mode. The block counts retired instructions for that thread. When a thread is switched out, its count is parked in a per-thread save table, and the count of the incoming thread is brought back from that table.

While recording, every cache access stamps the touched line with the current instruction count, thread number and sphere number. These stamps live in a tag store that is indexed by line, and they are not cleared when threads are switched. A remote coherence request can read a line's stamp back out, so that the stamp can travel with the outgoing dependence message. When a dependence message arrives from another processor, the block builds a log record. The record carries:

- the sender's thread number, sphere number and instruction count;
- the local instruction count at that moment;
- a log selector built from the local thread and sphere, so that the record lands in the log of the thread now running.

Records leave through a valid/ready port backed by one holding register.

Top module: `deprec_logger`

## Requirements
- R1: After synchronous reset the mode is standard (code 2'b00), the thread and sphere are 0, every count (live and saved) is 0, every line stamp is invalid, no record is pending, and dep_ready is 1.
- R2: Each cycle with retire high adds one to the live instruction count, which wraps modulo 2^ICNT_W.
- R3: A cfg_we cycle stores the outgoing thread's count (with that cycle's retire added) into its save slot, loads the mode, thread and sphere from cfg_mode, cfg_tid and cfg_sid, and makes the live count equal the saved count of cfg_tid (the value just stored if cfg_tid equals the outgoing thread).
- R4: In recording mode (code 2'b01), an acc_valid cycle writes the stamp {valid, live count, thread, sphere} of the current (pre-write) registers into line acc_idx. In standard (2'b00), replay (2'b10) or the spare code 2'b11, accesses leave every stamp unchanged.
- R5: A snoop_valid cycle gives tag_valid=1 on the next cycle, with tag_hit equal to the stamp's valid bit and tag_tid, tag_sid and tag_icnt equal to its fields. The stamp read is the one held before any same-cycle write. Stamps survive cfg_we writes.
- R6: In recording mode, an accepted dependence message (dep_valid and dep_ready) produces a record with log selector {current thread, current sphere}, the message's thread, sphere and count, and the live count before that cycle's retire.
- R7: Outside recording mode, dep_ready is 1 and dependence messages are absorbed without creating any record.
- R8: A pending record holds rec_valid and all rec_* fields stable until rec_ready. In recording mode, dep_ready is 0 exactly when a record is pending and rec_ready is 0. A record leaving and a new one entering in the same cycle is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Scheduling write (thread switch) |
| cfg_mode | input | 2 | New mode: 00 standard, 01 record, 10 replay, 11 spare |
| cfg_tid | input | TID_W | New thread number |
| cfg_sid | input | SID_W | New sphere number |
| retire | input | 1 | One instruction retired |
| acc_valid | input | 1 | Local cache access strobe |
| acc_idx | input | clog2(LINES) | Accessed line |
| snoop_valid | input | 1 | Remote stamp lookup request |
| snoop_idx | input | clog2(LINES) | Line to look up |
| tag_valid | output | 1 | Lookup result valid |
| tag_hit | output | 1 | Looked-up line holds a stamp |
| tag_tid | output | TID_W | Stamp thread number |
| tag_sid | output | SID_W | Stamp sphere number |
| tag_icnt | output | ICNT_W | Stamp instruction count |
| dep_valid | input | 1 | Incoming dependence message valid |
| dep_ready | output | 1 | Message accepted |
| dep_tid | input | TID_W | Sender thread number |
| dep_sid | input | SID_W | Sender sphere number |
| dep_icnt | input | ICNT_W | Sender instruction count |
| rec_valid | output | 1 | Record pending |
| rec_ready | input | 1 | Log side takes the record |
| rec_log_tid | output | TID_W | Log selector: local thread |
| rec_log_sid | output | SID_W | Log selector: local sphere |
| rec_src_tid | output | TID_W | Sender thread number |
| rec_src_sid | output | SID_W | Sender sphere number |
| rec_src_icnt | output | ICNT_W | Sender count |
| rec_dst_icnt | output | ICNT_W | Local count |

## Verification
The assertions assume that the log side may drop rec_ready at any time, and that a sender may raise dep_valid without waiting for dep_ready. They also assume that a message which is not accepted is simply lost rather than held. The stimulus drives every input with a fixed seed in all of these freedoms, so messages are often offered while the buffer is full and rec_ready is low. Mode changes are frequent enough to cover every mode code, including the spare one. Thread switches revisit earlier threads, so parked counts really are restored.

// File: rtl/deprec_pkg.sv
package deprec_pkg;

    parameter int TID_W  = 3;
    parameter int SID_W  = 2;
    parameter int ICNT_W = 16;
    localparam int NTHR  = 1 << TID_W;

    typedef logic [TID_W-1:0]  tid_t;
    typedef logic [SID_W-1:0]  sid_t;
    typedef logic [ICNT_W-1:0] icnt_t;

    typedef enum logic [1:0] {
        MODE_STD = 2'b00,
        MODE_REC = 2'b01,
        MODE_RPL = 2'b10,
        MODE_SPR = 2'b11
    } mode_e;

    typedef struct packed {
        logic  vld;
        icnt_t icnt;
        tid_t  tid;
        sid_t  sid;
    } ltag_t;

    typedef struct packed {
        tid_t  log_tid;
        sid_t  log_sid;
        tid_t  src_tid;
        sid_t  src_sid;
        icnt_t src_icnt;
        icnt_t dst_icnt;
    } drec_t;

    function automatic logic is_rec(mode_e m);
        return m == MODE_REC;
    endfunction

    function automatic icnt_t bump(icnt_t c, logic r);
        return c + icnt_t'(r);
    endfunction

endpackage

// File: rtl/deprec_ctx.sv
module deprec_ctx
    import deprec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cfg_we,
    input  mode_e cfg_mode,
    input  tid_t  cfg_tid,
    input  sid_t  cfg_sid,
    input  logic  retire,
    output mode_e cur_mode,
    output tid_t  cur_tid,
    output sid_t  cur_sid,
    output icnt_t cur_icnt
);

    icnt_t park [NTHR];
    icnt_t next_cnt;

    assign next_cnt = bump(cur_icnt, retire);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_mode <= MODE_STD;
            cur_tid  <= '0;
            cur_sid  <= '0;
            cur_icnt <= '0;
        end else if (cfg_we) begin
            cur_mode <= cfg_mode;
            cur_tid  <= cfg_tid;
            cur_sid  <= cfg_sid;
            cur_icnt <= (cfg_tid == cur_tid) ? next_cnt : park[cfg_tid];
        end else begin
            cur_icnt <= next_cnt;
        end
    end

    for (genvar t = 0; t < NTHR; t++) begin : g_park
        always_ff @(posedge clk) begin
            if (rst)
                park[t] <= '0;
            else if (cfg_we && cur_tid == tid_t'(t))
                park[t] <= next_cnt;
        end
    end

endmodule

// File: rtl/deprec_tagstore.sv
module deprec_tagstore
    import deprec_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ltag_t            wr_tag,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output ltag_t            rd_tag
);

    ltag_t line_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                line_q[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))
                line_q[i] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_tag   <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_tag <= line_q[rd_idx];
        end
    end

endmodule

// File: rtl/deprec_recbuf.sv
module deprec_recbuf
    import deprec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  drec_t in_rec,
    output logic  in_ready,
    output logic  out_valid,
    output drec_t out_rec,
    input  logic  out_ready
);

    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_rec   <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid)
                out_rec <= in_rec;
        end
    end

endmodule

// File: rtl/deprec_logger.sv
module deprec_logger
    import deprec_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_mode,
    input  logic [TID_W-1:0]  cfg_tid,
    input  logic [SID_W-1:0]  cfg_sid,
    input  logic              retire,
    input  logic              acc_valid,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic              snoop_valid,
    input  logic [IDX_W-1:0]  snoop_idx,
    output logic              tag_valid,
    output logic              tag_hit,
    output logic [TID_W-1:0]  tag_tid,
    output logic [SID_W-1:0]  tag_sid,
    output logic [ICNT_W-1:0] tag_icnt,
    input  logic              dep_valid,
    output logic              dep_ready,
    input  logic [TID_W-1:0]  dep_tid,
    input  logic [SID_W-1:0]  dep_sid,
    input  logic [ICNT_W-1:0] dep_icnt,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic [TID_W-1:0]  rec_log_tid,
    output logic [SID_W-1:0]  rec_log_sid,
    output logic [TID_W-1:0]  rec_src_tid,
    output logic [SID_W-1:0]  rec_src_sid,
    output logic [ICNT_W-1:0] rec_src_icnt,
    output logic [ICNT_W-1:0] rec_dst_icnt
);

    mode_e cur_mode;
    tid_t  cur_tid;
    sid_t  cur_sid;
    icnt_t cur_icnt;
    logic  recording;
    ltag_t stamp;
    ltag_t rd_tag;
    drec_t new_rec;
    drec_t out_rec;
    logic  buf_ready;

    deprec_ctx u_ctx (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_mode (mode_e'(cfg_mode)),
        .cfg_tid  (cfg_tid),
        .cfg_sid  (cfg_sid),
        .retire   (retire),
        .cur_mode (cur_mode),
        .cur_tid  (cur_tid),
        .cur_sid  (cur_sid),
        .cur_icnt (cur_icnt)
    );

    assign recording = is_rec(cur_mode);

    always_comb begin
        stamp.vld  = 1'b1;
        stamp.icnt = cur_icnt;
        stamp.tid  = cur_tid;
        stamp.sid  = cur_sid;
    end

    deprec_tagstore #(.LINES(LINES)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (acc_valid && recording),
        .wr_idx   (acc_idx),
        .wr_tag   (stamp),
        .rd_en    (snoop_valid),
        .rd_idx   (snoop_idx),
        .rd_valid (tag_valid),
        .rd_tag   (rd_tag)
    );

    assign tag_hit  = rd_tag.vld;
    assign tag_tid  = rd_tag.tid;
    assign tag_sid  = rd_tag.sid;
    assign tag_icnt = rd_tag.icnt;

    always_comb begin
        new_rec.log_tid  = cur_tid;
        new_rec.log_sid  = cur_sid;
        new_rec.src_tid  = dep_tid;
        new_rec.src_sid  = dep_sid;
        new_rec.src_icnt = dep_icnt;
        new_rec.dst_icnt = cur_icnt;
    end

    deprec_recbuf u_buf (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (dep_valid && recording),
        .in_rec    (new_rec),
        .in_ready  (buf_ready),
        .out_valid (rec_valid),
        .out_rec   (out_rec),
        .out_ready (rec_ready)
    );

    assign dep_ready    = !recording || buf_ready;
    assign rec_log_tid  = out_rec.log_tid;
    assign rec_log_sid  = out_rec.log_sid;
    assign rec_src_tid  = out_rec.src_tid;
    assign rec_src_sid  = out_rec.src_sid;
    assign rec_src_icnt = out_rec.src_icnt;
    assign rec_dst_icnt = out_rec.dst_icnt;

endmodule

// File: rtl/deprec_logger_chk.sv
module deprec_logger_chk
    import deprec_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  cfg_we,
    input logic  retire,
    input icnt_t cur_icnt,
    input mode_e cur_mode,
    input logic  snoop_valid,
    input logic  tag_valid,
    input logic  dep_ready,
    input logic  rec_valid,
    input logic  rec_ready,
    input icnt_t rec_dst_icnt,
    input icnt_t rec_src_icnt,
    input tid_t  rec_log_tid
);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> cur_icnt == $past(cur_icnt) + icnt_t'($past(retire)));

    assert_lookup_latency_R5: assert property (@(posedge clk) disable iff (rst)
        snoop_valid |=> tag_valid);

    assert_no_spurious_lookup_R5: assert property (@(posedge clk) disable iff (rst)
        !snoop_valid |=> !tag_valid);

    assert_absorb_outside_rec_R7: assert property (@(posedge clk) disable iff (rst)
        cur_mode != MODE_REC |-> dep_ready);

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_dst_icnt)
                                   && $stable(rec_src_icnt) && $stable(rec_log_tid));

    assert_backpressure_R8: assert property (@(posedge clk) disable iff (rst)
        cur_mode == MODE_REC && rec_valid && !rec_ready |-> !dep_ready);

endmodule

bind deprec_logger deprec_logger_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .retire       (retire),
    .cur_icnt     (cur_icnt),
    .cur_mode     (cur_mode),
    .snoop_valid  (snoop_valid),
    .tag_valid    (tag_valid),
    .dep_ready    (dep_ready),
    .rec_valid    (rec_valid),
    .rec_ready    (rec_ready),
    .rec_dst_icnt (rec_dst_icnt),
    .rec_src_icnt (rec_src_icnt),
    .rec_log_tid  (rec_log_tid)
);

// File: tb/sim_deprec_logger.sv
`timescale 1ns/1ps
module sim_deprec_logger;
    import deprec_pkg::*;

    localparam int LINES = 16;
    localparam int IDX_W = $clog2(LINES);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic cfg_we = 0, retire = 0, acc_valid = 0, snoop_valid = 0;
    logic dep_valid = 0, rec_ready = 0;
    logic [1:0] cfg_mode = 0;
    tid_t cfg_tid = 0, dep_tid = 0;
    sid_t cfg_sid = 0, dep_sid = 0;
    icnt_t dep_icnt = 0;
    logic [IDX_W-1:0] acc_idx = 0, snoop_idx = 0;

    logic tag_valid, tag_hit, dep_ready, rec_valid;
    tid_t tag_tid, rec_log_tid, rec_src_tid;
    sid_t tag_sid, rec_log_sid, rec_src_sid;
    icnt_t tag_icnt, rec_src_icnt, rec_dst_icnt;

    deprec_logger #(.LINES(LINES)) u0 (.*);

    // reference model state
    int m_mode, m_tid, m_sid, m_cnt;
    int m_park [NTHR];
    bit m_lv [LINES];
    int m_lc [LINES], m_lt [LINES], m_ls [LINES];
    bit m_ov, m_oh;
    int m_oc, m_ot, m_os;
    bit m_full;
    int r_lt, r_ls, r_st, r_ss, r_sc, r_dc;

    int n_chk = 0, n_err = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_tid = 0; m_sid = 0; m_cnt = 0;
            foreach (m_park[t]) m_park[t] = 0;
            foreach (m_lv[i]) m_lv[i] = 0;
            m_ov = 0; m_full = 0;
        end else begin
            bit rdy;
            int nxt;
            m_ov = snoop_valid;
            if (snoop_valid) begin
                m_oh = m_lv[snoop_idx]; m_oc = m_lc[snoop_idx];
                m_ot = m_lt[snoop_idx]; m_os = m_ls[snoop_idx];
            end
            if (m_mode == 1 && acc_valid) begin
                m_lv[acc_idx] = 1; m_lc[acc_idx] = m_cnt;
                m_lt[acc_idx] = m_tid; m_ls[acc_idx] = m_sid;
            end
            rdy = (m_mode != 1) || !m_full || rec_ready;
            if (m_full && rec_ready) m_full = 0;
            if (dep_valid && rdy && m_mode == 1) begin
                m_full = 1;
                r_lt = m_tid; r_ls = m_sid; r_st = dep_tid; r_ss = dep_sid;
                r_sc = dep_icnt; r_dc = m_cnt;
            end
            nxt = (m_cnt + (retire ? 1 : 0)) % (1 << ICNT_W);
            if (cfg_we) begin
                m_park[m_tid] = nxt;
                m_mode = cfg_mode; m_tid = cfg_tid; m_sid = cfg_sid;
                m_cnt = m_park[cfg_tid];
            end else begin
                m_cnt = nxt;
            end
        end
    end

    task automatic compare();
        chk("R7/R8 rec_valid", rec_valid, m_full);
        if (m_full) begin
            chk("R6 log_tid", rec_log_tid, r_lt);
            chk("R6 log_sid", rec_log_sid, r_ls);
            chk("R6 src_tid", rec_src_tid, r_st);
            chk("R6 src_sid", rec_src_sid, r_ss);
            chk("R6 src_icnt", rec_src_icnt, r_sc);
            chk("R2/R3/R6 dst_icnt", rec_dst_icnt, r_dc);
        end
        chk("R5 tag_valid", tag_valid, m_ov);
        if (m_ov) begin
            chk("R4/R5 tag_hit", tag_hit, m_oh);
            if (m_oh) begin
                chk("R4/R5 tag_tid", tag_tid, m_ot);
                chk("R4/R5 tag_sid", tag_sid, m_os);
                chk("R2/R3/R4 tag_icnt", tag_icnt, m_oc);
            end
        end
    endtask

    task automatic drive(int pct_cfg, int pct_ready);
        cfg_we      = ($urandom_range(99) < pct_cfg);
        cfg_mode    = 2'($urandom_range(3));
        cfg_tid     = tid_t'($urandom_range(NTHR - 1));
        cfg_sid     = sid_t'($urandom);
        retire      = $urandom_range(1);
        acc_valid   = ($urandom_range(99) < 40);
        acc_idx     = IDX_W'($urandom_range(LINES - 1));
        snoop_valid = ($urandom_range(99) < 50);
        snoop_idx   = IDX_W'($urandom_range(LINES - 1));
        dep_valid   = ($urandom_range(99) < 45);
        dep_tid     = tid_t'($urandom);
        dep_sid     = sid_t'($urandom);
        dep_icnt    = icnt_t'($urandom);
        rec_ready   = ($urandom_range(99) < pct_ready);
    endtask

    bit done = 0;

    initial begin
        void'($urandom(7));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        chk("R1 rec_valid", rec_valid, 0);
        chk("R1 tag_valid", tag_valid, 0);
        chk("R1 dep_ready", dep_ready, 1);
        snoop_valid = 1; snoop_idx = 5;
        @(negedge clk);
        chk("R1 tag_hit after reset", tag_hit, 0);
        compare();
        for (int ph = 0; ph < 4; ph++) begin
            for (int c = 0; c < 2500; c++) begin
                @(negedge clk);
                compare();
                drive(ph == 1 ? 2 : 8, ph == 2 ? 10 : 60);
                #0.5;
                chk("R7/R8 dep_ready", dep_ready,
                    ((m_mode != 1) || !m_full || rec_ready) ? 1 : 0);
            end
        end
        @(negedge clk);
        compare();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=running expected=finished");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule